// File: doc/BRIEF.md
# Byte FIFO with Reset-Loaded Almost Thresholds

This block is a byte-wide synchronous FIFO that reports how close it is to either end through two programmable flags, alongside the usual full and empty indications. Software writes a 32-bit threshold word: the upper half sets how many bytes short of full the almost-full flag rises, and the lower half sets how many bytes above empty the almost-empty boundary lies.

The threshold word is only a staging value. The FIFO copies it into its own active thresholds when a FIFO clear is requested, and that same clear throws away every stored byte. A threshold word of zero at clear time selects a fallback offset of seven bytes on both sides. All four status outputs are registers that change on the same clock edge as the occupancy they describe.

Top module: `almost_flag_fifo`

## Requirements
- R1: After the synchronous active-low reset, empty=1, full=0, almost_empty=1, almost_full=0, the threshold word is zero and both active offsets are 7.
- R2: Bytes leave rd_data in the order they were accepted; rd_data is registered and shows the byte on the clock edge that accepts the read.
- R3: A write while full is ignored and a read while empty is ignored; an ignored read leaves rd_data unchanged and the occupancy untouched.
- R4: An accepted read and an accepted write in the same cycle leave the occupancy unchanged.
- R5: almost_full is 1 exactly when occupancy >= DEPTH - F, where F is the active almost-full offset taken from word bits 31:16.
- R6: almost_empty is 1 exactly when occupancy <= E + 1, where E is the active almost-empty offset taken from word bits 15:0.
- R7: Writing the threshold word does not change the active offsets or the flags until the next FIFO clear.
- R8: A FIFO clear discards all stored bytes; after its edge empty=1, full=0 and the flags reflect zero occupancy.
- R9: If the threshold word is zero when a clear is applied, both active offsets become 7; a word with only one half zero loads that half as offset 0.
- R10: The four status outputs are registered and reflect the occupancy that results from the same clock edge.
- R11: When a threshold write and a clear occur in the same cycle, the clear loads the word held before that edge; the new word takes effect at the following clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Threshold word write strobe |
| cfg_wdata | input | 32 | Threshold word: 31:16 almost-full offset, 15:0 almost-empty offset |
| fifo_clr | input | 1 | FIFO clear request: discard data, load thresholds |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Registered read byte |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| almost_full | output | 1 | Occupancy at or above the almost-full level |
| almost_empty | output | 1 | Occupancy at or below the almost-empty boundary |

## Verification
The hardest situation to reach is the gap between a staged threshold word and the active one, because the flags look identical until occupancy crosses a boundary that only one of the two values would place. The stimulus writes a new word, then fills the FIFO past the new boundary but short of the old one before any clear, and later repeats the check after a clear whose cycle also carries a threshold write. Each boundary is probed one byte below and one byte at the switching point so that an off-by-one in either comparison shows.

// File: rtl/afifo_pkg.sv
// Shared constants and flag arithmetic for the almost-flag FIFO.
// Assumes occupancy values fit in 32 bits.
package afifo_pkg;

    localparam int unsigned OFF_W       = 16;
    localparam int unsigned WORD_W      = 32;
    localparam logic [15:0] DEFAULT_OFF = 16'd7;

    // Almost-full level reached: occupancy plus offset meets the depth.
    function automatic logic af_calc(input logic [31:0] occ,
                                     input logic [15:0] off,
                                     input int unsigned depth);
        logic [32:0] sum;
        sum = {1'b0, occ} + {17'b0, off};
        return sum >= {1'b0, depth};
    endfunction

    // Almost-empty boundary: occupancy at or below offset plus one.
    function automatic logic ae_calc(input logic [31:0] occ,
                                     input logic [15:0] off);
        logic [32:0] lim;
        lim = {17'b0, off} + 33'd1;
        return {1'b0, occ} <= lim;
    endfunction

endpackage

// File: rtl/afifo_thresh.sv
// Threshold staging and activation.
// Holds the software-written threshold word and the two active offsets.
// The active offsets change only on reset or a FIFO clear; a zero word at
// that time selects the default offset on both sides.
module afifo_thresh
    import afifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              fifo_clr,
    output logic [31:0]       cfg_q,
    output logic [15:0]       af_off_q,
    output logic [15:0]       ae_off_q,
    output logic [15:0]       af_off_d,
    output logic [15:0]       ae_off_d
);

    logic word_zero;

    // Staged word register, written by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Next active offsets: loaded from the staged word on a clear only.
    always_comb begin
        word_zero = (cfg_q == '0);
        af_off_d  = af_off_q;
        ae_off_d  = ae_off_q;
        if (!rst_n) begin
            af_off_d = DEFAULT_OFF;
            ae_off_d = DEFAULT_OFF;
        end else if (fifo_clr) begin
            af_off_d = word_zero ? DEFAULT_OFF : cfg_q[31:16];
            ae_off_d = word_zero ? DEFAULT_OFF : cfg_q[15:0];
        end
    end

    // Active offset registers.
    always_ff @(posedge clk) begin
        af_off_q <= af_off_d;
        ae_off_q <= ae_off_d;
    end

endmodule

// File: rtl/afifo_store.sv
// Byte storage, pointers and occupancy counter.
// Assumes DEPTH >= 2. Writes while full and reads while empty are dropped.
// A clear or reset empties the store without touching the memory array.
module afifo_store #(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d
);

    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic          do_wr;
    logic          do_rd;
    logic          wipe;

    // Accept decisions from the current occupancy.
    always_comb begin
        wipe  = !rst_n || fifo_clr;
        do_wr = wr_en && (cnt_q != CNT_FULL) && !wipe;
        do_rd = rd_en && (cnt_q != '0) && !wipe;
    end

    // Next occupancy.
    always_comb begin
        cnt_d = cnt_q;
        if (wipe) begin
            cnt_d = '0;
        end else if (do_wr && !do_rd) begin
            cnt_d = cnt_q + 1'b1;
        end else if (do_rd && !do_wr) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Occupancy and pointer registers.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
        if (wipe) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_rd) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    end

    // Memory array write.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr_q] <= wr_data;
        end
    end

    // Registered read data, held when no read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (do_rd) begin
            rd_data <= mem[rd_ptr_q];
        end
    end

endmodule

// File: rtl/afifo_flags.sv
// Registered status flags.
// Computes full, empty, almost-full and almost-empty from the occupancy and
// offsets that will hold after the current edge, so each flag changes on
// the same edge as the occupancy it describes.
module afifo_flags
    import afifo_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic [CW-1:0] cnt_d,
    input  logic [15:0]   af_off_d,
    input  logic [15:0]   ae_off_d,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);

    logic [31:0] occ_next;

    // Widen the next occupancy for the comparisons.
    always_comb begin
        occ_next = 32'(cnt_d);
    end

    // Flag registers; reset is carried through cnt_d and the offsets.
    always_ff @(posedge clk) begin
        full         <= (occ_next == DEPTH);
        empty        <= (occ_next == 32'd0);
        almost_full  <= af_calc(occ_next, af_off_d, DEPTH);
        almost_empty <= ae_calc(occ_next, ae_off_d);
    end

endmodule

// File: rtl/almost_flag_fifo.sv
// Top level: byte FIFO whose almost thresholds load on a FIFO clear.
// Assumes a single clock; rst_n is synchronous and active low and acts as a
// clear with a zero threshold word.
module almost_flag_fifo #(
    parameter int unsigned DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        fifo_clr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic        full,
    output logic        empty,
    output logic        almost_full,
    output logic        almost_empty
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic [31:0]   cfg_q;
    logic [15:0]   af_off_q;
    logic [15:0]   ae_off_q;
    logic [15:0]   af_off_d;
    logic [15:0]   ae_off_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    afifo_thresh u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .fifo_clr  (fifo_clr),
        .cfg_q     (cfg_q),
        .af_off_q  (af_off_q),
        .ae_off_q  (ae_off_q),
        .af_off_d  (af_off_d),
        .ae_off_d  (ae_off_d)
    );

    afifo_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_clr (fifo_clr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d)
    );

    afifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk          (clk),
        .cnt_d        (cnt_d),
        .af_off_d     (af_off_d),
        .ae_off_d     (ae_off_d),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

endmodule

// File: rtl/almost_flag_fifo_chk.sv
// Property checker for almost_flag_fifo, attached by bind below.
// Waits one cycle after reset release before judging history.
module almost_flag_fifo_chk #(
    parameter int unsigned CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          full,
    input logic          empty,
    input logic          almost_full,
    input logic          almost_empty,
    input logic [31:0]   cfg_q,
    input logic [15:0]   af_off_q,
    input logic [15:0]   ae_off_q,
    input logic [CW-1:0] cnt_q
);

    logic settled;

    // Marks that at least one cycle has passed out of reset.
    always_ff @(posedge clk) begin
        settled <= rst_n;
    end

    assert_no_overflow_R3: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        (full && wr_en && !rd_en && !fifo_clr) |=> (full && $stable(cnt_q)));

    assert_no_underflow_R3: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        (empty && rd_en && !wr_en && !fifo_clr) |=> (empty && $stable(rd_data)));

    assert_simul_hold_R4: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        (wr_en && rd_en && !full && !empty && !fifo_clr) |=> $stable(cnt_q));

    assert_full_implies_af_R5: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        full |-> almost_full);

    assert_empty_implies_ae_R6: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        empty |-> almost_empty);

    assert_thresh_hold_R7: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        !fifo_clr |=> ($stable(af_off_q) && $stable(ae_off_q)));

    assert_clear_empties_R8: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        fifo_clr |=> (empty && !full && almost_empty));

    assert_zero_default_R9: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        (fifo_clr && cfg_q == 32'd0) |=> (af_off_q == 16'd7 && ae_off_q == 16'd7));

endmodule

bind almost_flag_fifo almost_flag_fifo_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_clr     (fifo_clr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .full         (full),
    .empty        (empty),
    .almost_full  (almost_full),
    .almost_empty (almost_empty),
    .cfg_q        (cfg_q),
    .af_off_q     (af_off_q),
    .ae_off_q     (ae_off_q),
    .cnt_q        (cnt_q)
);

// File: tb/almost_flag_fifo_tb.sv
// Directed bench for almost_flag_fifo with a 64-byte FIFO.
module almost_flag_fifo_tb;

    localparam int unsigned DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        fifo_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        full, empty, almost_full, almost_empty;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    almost_flag_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic set_cfg(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
    endtask

    task automatic fill(input int n, input int base);
        for (int i = 0; i < n; i++) push(8'(base + i));
    endtask

    task automatic test_reset();
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "almost_empty", int'(almost_empty), 1);
        chk("R1", "almost_full", int'(almost_full), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
    endtask

    // Default offsets 7: ae boundary 8, af level 57; fill, overflow, drain.
    task automatic test_default_fill();
        logic [7:0] d;
        for (int i = 0; i < 8; i++) push(8'(i * 3 + 1));
        chk("R6", "ae at 8 bytes", int'(almost_empty), 1);
        push(8'(8 * 3 + 1));
        chk("R10", "ae falls on the 9th write edge", int'(almost_empty), 0);
        for (int i = 9; i < 56; i++) push(8'(i * 3 + 1));
        chk("R5", "af at 56 bytes", int'(almost_full), 0);
        push(8'(56 * 3 + 1));
        chk("R5", "af at 57 bytes", int'(almost_full), 1);
        for (int i = 57; i < 64; i++) push(8'(i * 3 + 1));
        chk("R3", "full at depth", int'(full), 1);
        push(8'hEE);
        chk("R3", "full after extra write", int'(full), 1);
        for (int i = 0; i < 64; i++) begin
            pop(d);
            if (d != 8'(i * 3 + 1)) chk("R2", "read order", int'(d), i * 3 + 1);
            else chk("R2", "read order", int'(d), int'(d));
        end
        chk("R3", "empty after draining, extra write dropped", int'(empty), 1);
        pop(d);
        chk("R3", "rd_data held on empty read", int'(d), 63 * 3 + 1);
        chk("R3", "still empty", int'(empty), 1);
    endtask

    // Staged word has no effect until a clear; clear discards data.
    task automatic test_deferred();
        logic [7:0] d;
        set_cfg(32'h0004_0002);
        fill(5, 40);
        chk("R7", "ae still uses old boundary at 5 bytes", int'(almost_empty), 1);
        clear();
        chk("R8", "empty after clear", int'(empty), 1);
        chk("R8", "full after clear", int'(full), 0);
        chk("R8", "ae after clear", int'(almost_empty), 1);
        pop(d);
        chk("R8", "no data after clear", int'(d), 63 * 3 + 1);
        fill(3, 0);
        chk("R6", "ae at 3 bytes, offset 2", int'(almost_empty), 1);
        push(8'd3);
        chk("R6", "ae at 4 bytes, offset 2", int'(almost_empty), 0);
        fill(55, 4);
        chk("R5", "af at 59 bytes, offset 4", int'(almost_full), 0);
        push(8'd99);
        chk("R5", "af at 60 bytes, offset 4", int'(almost_full), 1);
        clear();
        chk("R8", "af cleared with data", int'(almost_full), 0);
    endtask

    task automatic test_zero_default();
        set_cfg(32'h0000_0000);
        clear();
        fill(8, 0);
        chk("R9", "ae at 8 bytes, default", int'(almost_empty), 1);
        push(8'd8);
        chk("R9", "ae at 9 bytes, default", int'(almost_empty), 0);
        clear();
    endtask

    task automatic test_half_zero();
        set_cfg(32'h0000_0005);
        clear();
        fill(6, 0);
        chk("R9", "ae at 6 bytes, offset 5", int'(almost_empty), 1);
        push(8'd6);
        chk("R6", "ae at 7 bytes, offset 5", int'(almost_empty), 0);
        fill(56, 7);
        chk("R9", "af at 63 bytes, offset 0", int'(almost_full), 0);
        push(8'd77);
        chk("R9", "af at 64 bytes, offset 0", int'(almost_full), 1);
        chk("R5", "full at 64 bytes", int'(full), 1);
        clear();
    endtask

    // Write and clear in one cycle: old word loads, new one next time.
    task automatic test_same_cycle();
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0003_0003; fifo_clr = 1'b1;
        @(negedge clk); cfg_we = 1'b0; fifo_clr = 1'b0;
        fill(6, 0);
        chk("R11", "ae at 6 bytes uses old offset 5", int'(almost_empty), 1);
        push(8'd6);
        chk("R11", "ae at 7 bytes uses old offset 5", int'(almost_empty), 0);
        clear();
        fill(4, 0);
        chk("R11", "ae at 4 bytes uses new offset 3", int'(almost_empty), 1);
        push(8'd4);
        chk("R11", "ae at 5 bytes uses new offset 3", int'(almost_empty), 0);
        clear();
    endtask

    // Simultaneous read and write keep occupancy at 10.
    task automatic test_simul();
        logic [7:0] d;
        int cnt;
        fill(10, 100);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'(200 + k);
            @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
            chk("R4", "read during simultaneous access", int'(rd_data), 100 + k);
        end
        chk("R4", "ae low after simultaneous access", int'(almost_empty), 0);
        cnt = 0;
        while (!empty && cnt < 20) begin
            pop(d);
            if (cnt < 5) chk("R2", "order after simul", int'(d), 105 + cnt);
            else chk("R2", "order after simul", int'(d), 200 + cnt - 5);
            cnt++;
        end
        chk("R4", "occupancy after simultaneous access", cnt, 10);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_default_fill();
        test_deferred();
        test_zero_default();
        test_half_zero();
        test_same_cycle();
        test_simul();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule